// File: doc/BRIEF.md
# Transaction ID Extender for a Many-to-One Interconnect Port

This block joins several AXI-style master ports to one slave port. On the read-address, write-address and write-data channels it picks one master per channel with a round-robin arbiter. It forwards that master's beat with a widened ID that carries the master's port number. Masters can therefore reuse any ID values without knowing what the other masters use, and the slave sees IDs that are unique across the whole system.

On the read-data and write-response channels the block reads the port-number field of the returned ID. It sends the beat to that master only, and removes the field so that the master gets back exactly the ID it issued. A returned beat whose port number names no existing master is accepted and discarded, so a bad ID cannot stall the slave. Backpressure passes straight through in both directions, and no beat is buffered.

Top module: `axi_id_ext`

## Requirements
- R1: On every request channel (read address, write address, write data), the slave-side ID is `{port number zero-extended to PORT_W bits, master ID}`. The port number is in bits [SID_W-1:MID_W], the master's ID is in bits [MID_W-1:0], and SID_W = MID_W + PORT_W (4 + 4 = 8 by default).
- R2: The address, write data and write-last of the granted master reach the slave port unchanged.
- R3: Each request channel arbitrates round-robin. When no grant is held, the grant goes to the first requesting master after the one that completed the last handshake, counting upward with wrap-around.
- R4: Once a request is offered to the slave with ready low, the grant and the slave-side ID and payload stay unchanged until the handshake completes.
- R5: At most one master's ready is high per request channel. It is high only for the granted, valid master, and only while the slave's ready is high. All other masters see ready low.
- R6: A read-data beat goes to the master named by returned ID bits [SID_W-1:MID_W]. Only that master's valid is raised, and it carries the slave's data and last.
- R7: The ID presented to masters on read data is the returned ID's bits [MID_W-1:0].
- R8: Write responses are routed by the same port-number bits and stripped to bits [MID_W-1:0], with the response code passed through.
- R9: A response beat whose port number is N_MST or more is accepted (slave-side ready high), and no master's valid rises.
- R10: For a response to an existing master, the slave-side ready equals that master's ready.
- R11: Masters that all drive ID 0 still produce distinct slave-side IDs, equal to their port number in the upper field.
- R12: After reset no request valid reaches the slave. If all masters request at once, the first grant goes to master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_ar_valid_i | input | N_MST | Read-address valid per master |
| m_ar_id_i | input | N_MST*MID_W | Read-address ID per master |
| m_ar_addr_i | input | N_MST*ADDR_W | Read address per master |
| m_ar_ready_o | output | N_MST | Read-address ready per master |
| s_ar_valid_o | output | 1 | Read-address valid to slave |
| s_ar_id_o | output | SID_W | Widened read-address ID |
| s_ar_addr_o | output | ADDR_W | Read address to slave |
| s_ar_ready_i | input | 1 | Slave read-address ready |
| m_aw_valid_i | input | N_MST | Write-address valid per master |
| m_aw_id_i | input | N_MST*MID_W | Write-address ID per master |
| m_aw_addr_i | input | N_MST*ADDR_W | Write address per master |
| m_aw_ready_o | output | N_MST | Write-address ready per master |
| s_aw_valid_o | output | 1 | Write-address valid to slave |
| s_aw_id_o | output | SID_W | Widened write-address ID |
| s_aw_addr_o | output | ADDR_W | Write address to slave |
| s_aw_ready_i | input | 1 | Slave write-address ready |
| m_w_valid_i | input | N_MST | Write-data valid per master |
| m_w_id_i | input | N_MST*MID_W | Write-data ID per master |
| m_w_data_i | input | N_MST*DATA_W | Write data per master |
| m_w_last_i | input | N_MST | Write-last per master |
| m_w_ready_o | output | N_MST | Write-data ready per master |
| s_w_valid_o | output | 1 | Write-data valid to slave |
| s_w_id_o | output | SID_W | Widened write-data ID |
| s_w_data_o | output | DATA_W | Write data to slave |
| s_w_last_o | output | 1 | Write-last to slave |
| s_w_ready_i | input | 1 | Slave write-data ready |
| s_r_valid_i | input | 1 | Read-data valid from slave |
| s_r_id_i | input | SID_W | Returned read ID |
| s_r_data_i | input | DATA_W | Read data from slave |
| s_r_last_i | input | 1 | Read-last from slave |
| s_r_ready_o | output | 1 | Read-data ready to slave |
| m_r_valid_o | output | N_MST | Read-data valid per master |
| m_r_id_o | output | MID_W | Stripped read ID |
| m_r_data_o | output | DATA_W | Read data to masters |
| m_r_last_o | output | 1 | Read-last to masters |
| m_r_ready_i | input | N_MST | Read-data ready per master |
| s_b_valid_i | input | 1 | Write-response valid from slave |
| s_b_id_i | input | SID_W | Returned write-response ID |
| s_b_resp_i | input | 2 | Write-response code |
| s_b_ready_o | output | 1 | Write-response ready to slave |
| m_b_valid_o | output | N_MST | Write-response valid per master |
| m_b_id_o | output | MID_W | Stripped write-response ID |
| m_b_resp_o | output | 2 | Write-response code to masters |
| m_b_ready_i | input | N_MST | Write-response ready per master |

## Verification
Two functions meet in one cycle: a request channel may hold a stalled grant while another master raises a new request, and a response may come back for the master that is being stalled or granted. The stimulus keeps slave-side readies randomly low and adds new requests on every channel in the same cycles. It also drives random response IDs whose port field covers both real and absent masters, with random master readies. Every cycle the bench computes the expected grant, widened ID, payload, ready vectors and routed response from its own round-robin model, and compares them with the ports.

// File: rtl/axi_id_ext_pkg.sv
package axi_id_ext_pkg;
  function automatic int unsigned sel_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/id_rr_arb.sv
module id_rr_arb #(
  parameter int unsigned N     = 4,
  localparam int unsigned SEL_W = axi_id_ext_pkg::sel_width(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             hold_i,
  input  logic             done_i,
  output logic [SEL_W-1:0] gnt_o
);
  logic [SEL_W-1:0] ptr_q, gnt_q, pick;
  logic             lock_q, found;

  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    for (int k = 1; k <= int'(N); k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % int'(N);
      if (!found && req_i[idx]) begin
        pick  = SEL_W'(idx);
        found = 1'b1;
      end
    end
    gnt_o = lock_q ? gnt_q : pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= SEL_W'(N - 1);
      gnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      lock_q <= hold_i;
      if (hold_i) gnt_q <= gnt_o;
      if (done_i) ptr_q <= gnt_o;
    end
  end

  p_grant_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> gnt_o == $past(gnt_o));
  p_grant_requester_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && |req_i) |-> req_i[gnt_o]);
endmodule

// File: rtl/id_req_chan.sv
module id_req_chan #(
  parameter int unsigned N      = 4,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned PORT_W = 4,
  parameter int unsigned PAY_W  = 32,
  localparam int unsigned SID_W = MID_W + PORT_W,
  localparam int unsigned SEL_W = axi_id_ext_pkg::sel_width(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       m_valid_i,
  input  logic [N*MID_W-1:0] m_id_i,
  input  logic [N*PAY_W-1:0] m_pay_i,
  output logic [N-1:0]       m_ready_o,
  output logic               s_valid_o,
  output logic [SID_W-1:0]   s_id_o,
  output logic [PAY_W-1:0]   s_pay_o,
  input  logic               s_ready_i
);
  logic [SEL_W-1:0] gnt;

  id_rr_arb #(.N(N)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (m_valid_i),
    .hold_i (s_valid_o && !s_ready_i),
    .done_i (s_valid_o && s_ready_i),
    .gnt_o  (gnt)
  );

  always_comb begin
    s_valid_o      = m_valid_i[gnt];
    s_id_o         = {PORT_W'(gnt), m_id_i[int'(gnt)*MID_W +: MID_W]};
    s_pay_o        = m_pay_i[int'(gnt)*PAY_W +: PAY_W];
    m_ready_o      = '0;
    m_ready_o[gnt] = s_ready_i & m_valid_i[gnt];
  end

  p_ready_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_ready_o));
  p_ready_needs_slave_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |m_ready_o |-> (s_ready_i && s_valid_o));
  p_stall_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_o && !s_ready_i) |=> ($stable(s_id_o[SID_W-1:MID_W]) && s_valid_o));
endmodule

// File: rtl/id_rsp_chan.sv
module id_rsp_chan #(
  parameter int unsigned N      = 4,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned PORT_W = 4,
  parameter int unsigned PAY_W  = 33,
  localparam int unsigned SID_W = MID_W + PORT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic [SID_W-1:0] s_id_i,
  input  logic [PAY_W-1:0] s_pay_i,
  output logic             s_ready_o,
  output logic [N-1:0]     m_valid_o,
  output logic [MID_W-1:0] m_id_o,
  output logic [PAY_W-1:0] m_pay_o,
  input  logic [N-1:0]     m_ready_i
);
  logic [PORT_W-1:0] port;

  assign port    = s_id_i[SID_W-1:MID_W];
  assign m_id_o  = s_id_i[MID_W-1:0];
  assign m_pay_o = s_pay_i;

  // unknown port: default ready high, beat dropped
  always_comb begin
    m_valid_o = '0;
    s_ready_o = 1'b1;
    for (int i = 0; i < int'(N); i++) begin
      if (int'(port) == i) begin
        m_valid_o[i] = s_valid_i;
        s_ready_o    = m_ready_i[i];
      end
    end
  end

  p_rsp_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_valid_o));
  p_rsp_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |m_valid_o |-> s_valid_i);
  p_rsp_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && int'(s_id_i[SID_W-1:MID_W]) >= int'(N)) |-> (s_ready_o && m_valid_o == '0));
endmodule

// File: rtl/axi_id_ext.sv
module axi_id_ext #(
  parameter int unsigned N_MST  = 4,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned PORT_W = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SID_W = MID_W + PORT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        m_ar_valid_i,
  input  logic [N_MST*MID_W-1:0]  m_ar_id_i,
  input  logic [N_MST*ADDR_W-1:0] m_ar_addr_i,
  output logic [N_MST-1:0]        m_ar_ready_o,
  output logic                    s_ar_valid_o,
  output logic [SID_W-1:0]        s_ar_id_o,
  output logic [ADDR_W-1:0]       s_ar_addr_o,
  input  logic                    s_ar_ready_i,
  input  logic [N_MST-1:0]        m_aw_valid_i,
  input  logic [N_MST*MID_W-1:0]  m_aw_id_i,
  input  logic [N_MST*ADDR_W-1:0] m_aw_addr_i,
  output logic [N_MST-1:0]        m_aw_ready_o,
  output logic                    s_aw_valid_o,
  output logic [SID_W-1:0]        s_aw_id_o,
  output logic [ADDR_W-1:0]       s_aw_addr_o,
  input  logic                    s_aw_ready_i,
  input  logic [N_MST-1:0]        m_w_valid_i,
  input  logic [N_MST*MID_W-1:0]  m_w_id_i,
  input  logic [N_MST*DATA_W-1:0] m_w_data_i,
  input  logic [N_MST-1:0]        m_w_last_i,
  output logic [N_MST-1:0]        m_w_ready_o,
  output logic                    s_w_valid_o,
  output logic [SID_W-1:0]        s_w_id_o,
  output logic [DATA_W-1:0]       s_w_data_o,
  output logic                    s_w_last_o,
  input  logic                    s_w_ready_i,
  input  logic                    s_r_valid_i,
  input  logic [SID_W-1:0]        s_r_id_i,
  input  logic [DATA_W-1:0]       s_r_data_i,
  input  logic                    s_r_last_i,
  output logic                    s_r_ready_o,
  output logic [N_MST-1:0]        m_r_valid_o,
  output logic [MID_W-1:0]        m_r_id_o,
  output logic [DATA_W-1:0]       m_r_data_o,
  output logic                    m_r_last_o,
  input  logic [N_MST-1:0]        m_r_ready_i,
  input  logic                    s_b_valid_i,
  input  logic [SID_W-1:0]        s_b_id_i,
  input  logic [1:0]              s_b_resp_i,
  output logic                    s_b_ready_o,
  output logic [N_MST-1:0]        m_b_valid_o,
  output logic [MID_W-1:0]        m_b_id_o,
  output logic [1:0]              m_b_resp_o,
  input  logic [N_MST-1:0]        m_b_ready_i
);
  localparam int unsigned WPAY_W = DATA_W + 1;

  logic [N_MST*WPAY_W-1:0] w_pay;
  logic [WPAY_W-1:0]       s_w_pay;

  for (genvar i = 0; i < N_MST; i++) begin : g_wpack
    assign w_pay[i*WPAY_W +: WPAY_W] = {m_w_last_i[i], m_w_data_i[i*DATA_W +: DATA_W]};
  end
  assign {s_w_last_o, s_w_data_o} = s_w_pay;

  id_req_chan #(.N(N_MST), .MID_W(MID_W), .PORT_W(PORT_W), .PAY_W(ADDR_W)) u_ar (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .m_valid_i(m_ar_valid_i), .m_id_i(m_ar_id_i), .m_pay_i(m_ar_addr_i), .m_ready_o(m_ar_ready_o),
    .s_valid_o(s_ar_valid_o), .s_id_o(s_ar_id_o), .s_pay_o(s_ar_addr_o), .s_ready_i(s_ar_ready_i)
  );

  id_req_chan #(.N(N_MST), .MID_W(MID_W), .PORT_W(PORT_W), .PAY_W(ADDR_W)) u_aw (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .m_valid_i(m_aw_valid_i), .m_id_i(m_aw_id_i), .m_pay_i(m_aw_addr_i), .m_ready_o(m_aw_ready_o),
    .s_valid_o(s_aw_valid_o), .s_id_o(s_aw_id_o), .s_pay_o(s_aw_addr_o), .s_ready_i(s_aw_ready_i)
  );

  id_req_chan #(.N(N_MST), .MID_W(MID_W), .PORT_W(PORT_W), .PAY_W(WPAY_W)) u_w (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .m_valid_i(m_w_valid_i), .m_id_i(m_w_id_i), .m_pay_i(w_pay), .m_ready_o(m_w_ready_o),
    .s_valid_o(s_w_valid_o), .s_id_o(s_w_id_o), .s_pay_o(s_w_pay), .s_ready_i(s_w_ready_i)
  );

  id_rsp_chan #(.N(N_MST), .MID_W(MID_W), .PORT_W(PORT_W), .PAY_W(WPAY_W)) u_r (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_valid_i(s_r_valid_i), .s_id_i(s_r_id_i), .s_pay_i({s_r_last_i, s_r_data_i}), .s_ready_o(s_r_ready_o),
    .m_valid_o(m_r_valid_o), .m_id_o(m_r_id_o), .m_pay_o({m_r_last_o, m_r_data_o}), .m_ready_i(m_r_ready_i)
  );

  id_rsp_chan #(.N(N_MST), .MID_W(MID_W), .PORT_W(PORT_W), .PAY_W(2)) u_b (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_valid_i(s_b_valid_i), .s_id_i(s_b_id_i), .s_pay_i(s_b_resp_i), .s_ready_o(s_b_ready_o),
    .m_valid_o(m_b_valid_o), .m_id_o(m_b_id_o), .m_pay_o(m_b_resp_o), .m_ready_i(m_b_ready_i)
  );
endmodule

// File: tb/axi_id_ext_bench.sv
module axi_id_ext_bench;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] m_ar_valid, m_aw_valid, m_w_valid, m_w_last;
  logic [15:0] m_ar_id, m_aw_id, m_w_id;
  logic [127:0] m_ar_addr, m_aw_addr, m_w_data;
  logic [3:0] m_ar_ready, m_aw_ready, m_w_ready;
  logic s_ar_valid, s_aw_valid, s_w_valid, s_w_last;
  logic [7:0] s_ar_id, s_aw_id, s_w_id;
  logic [31:0] s_ar_addr, s_aw_addr, s_w_data;
  logic s_ar_ready, s_aw_ready, s_w_ready;
  logic s_r_valid, s_r_last, s_r_ready, m_r_last;
  logic [7:0] s_r_id, s_b_id;
  logic [31:0] s_r_data, m_r_data;
  logic [3:0] m_r_valid, m_r_ready, m_r_id, m_b_valid, m_b_ready, m_b_id;
  logic s_b_valid, s_b_ready;
  logic [1:0] s_b_resp, m_b_resp;

  axi_id_ext u_axi_id_ext (
    .clk_i(clk), .rst_ni(rst_n),
    .m_ar_valid_i(m_ar_valid), .m_ar_id_i(m_ar_id), .m_ar_addr_i(m_ar_addr), .m_ar_ready_o(m_ar_ready),
    .s_ar_valid_o(s_ar_valid), .s_ar_id_o(s_ar_id), .s_ar_addr_o(s_ar_addr), .s_ar_ready_i(s_ar_ready),
    .m_aw_valid_i(m_aw_valid), .m_aw_id_i(m_aw_id), .m_aw_addr_i(m_aw_addr), .m_aw_ready_o(m_aw_ready),
    .s_aw_valid_o(s_aw_valid), .s_aw_id_o(s_aw_id), .s_aw_addr_o(s_aw_addr), .s_aw_ready_i(s_aw_ready),
    .m_w_valid_i(m_w_valid), .m_w_id_i(m_w_id), .m_w_data_i(m_w_data), .m_w_last_i(m_w_last),
    .m_w_ready_o(m_w_ready), .s_w_valid_o(s_w_valid), .s_w_id_o(s_w_id), .s_w_data_o(s_w_data),
    .s_w_last_o(s_w_last), .s_w_ready_i(s_w_ready),
    .s_r_valid_i(s_r_valid), .s_r_id_i(s_r_id), .s_r_data_i(s_r_data), .s_r_last_i(s_r_last),
    .s_r_ready_o(s_r_ready), .m_r_valid_o(m_r_valid), .m_r_id_o(m_r_id), .m_r_data_o(m_r_data),
    .m_r_last_o(m_r_last), .m_r_ready_i(m_r_ready),
    .s_b_valid_i(s_b_valid), .s_b_id_i(s_b_id), .s_b_resp_i(s_b_resp), .s_b_ready_o(s_b_ready),
    .m_b_valid_o(m_b_valid), .m_b_id_o(m_b_id), .m_b_resp_o(m_b_resp), .m_b_ready_i(m_b_ready)
  );

  int n_chk = 0, n_fail = 0;

  // bench model of masters and arbiters, channel 0=AR 1=AW 2=W
  logic [3:0]  vld  [3];
  logic [3:0]  idv  [3][4];
  logic [32:0] pay  [3][4];
  int          ptr  [3];
  bit          lock [3];
  int          lg   [3];
  int          g    [3];
  bit          ev   [3];
  bit          sr   [3];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pick(int ch);
    if (lock[ch]) return lg[ch];
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (ptr[ch] + k) % N;
      if (vld[ch][idx]) return idx;
    end
    return ptr[ch];
  endfunction

  function automatic logic [3:0] rand_id();
    return ($urandom % 4 == 0) ? 4'd0 : 4'($urandom);
  endfunction

  task automatic check_req(int ch, bit first, logic sv, logic [7:0] sid, logic [32:0] spay,
                           logic [3:0] mrdy);
    logic [3:0] erdy;
    g[ch]  = pick(ch);
    ev[ch] = vld[ch][g[ch]];
    chk("R3", 64'(sv), 64'(ev[ch]));
    if (ev[ch]) begin
      if (first) chk("R12", 64'(sid[7:4]), 64'(g[ch]));
      if (lock[ch]) chk("R4", 64'(sid[7:4]), 64'(lg[ch]));
      else chk("R3", 64'(sid[7:4]), 64'(g[ch]));
      if (idv[ch][g[ch]] == 4'd0) chk("R11", 64'(sid), 64'({4'(g[ch]), 4'd0}));
      else chk("R1", 64'(sid), 64'({4'(g[ch]), idv[ch][g[ch]]}));
      chk("R2", 64'(spay), 64'(pay[ch][g[ch]]));
    end
    erdy = (ev[ch] && sr[ch]) ? 4'(1 << g[ch]) : 4'd0;
    chk("R5", 64'(mrdy), 64'(erdy));
  endtask

  task automatic check_rsp(bit is_b, logic sv, logic [7:0] sid, logic [3:0] mrdy,
                           logic [3:0] mv, logic [3:0] mid, logic srdy);
    int p;
    p = int'(sid[7:4]);
    if (p < N) begin
      chk(is_b ? "R8" : "R6", 64'(mv), 64'(sv ? 4'(1 << p) : 4'd0));
      chk("R10", 64'(srdy), 64'(mrdy[p]));
    end else begin
      chk("R9", 64'(mv), 64'd0);
      chk("R9", 64'(srdy), 64'd1);
    end
    chk(is_b ? "R8" : "R7", 64'(mid), 64'(sid[3:0]));
  endtask

  task automatic drive();
    for (int m = 0; m < N; m++) begin
      m_ar_valid[m] = vld[0][m]; m_ar_id[m*4 +: 4] = idv[0][m]; m_ar_addr[m*32 +: 32] = pay[0][m][31:0];
      m_aw_valid[m] = vld[1][m]; m_aw_id[m*4 +: 4] = idv[1][m]; m_aw_addr[m*32 +: 32] = pay[1][m][31:0];
      m_w_valid[m]  = vld[2][m]; m_w_id[m*4 +: 4]  = idv[2][m]; m_w_data[m*32 +: 32]  = pay[2][m][31:0];
      m_w_last[m]   = pay[2][m][32];
    end
    s_ar_ready = sr[0]; s_aw_ready = sr[1]; s_w_ready = sr[2];
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      vld[c] = '0; ptr[c] = N - 1; lock[c] = 0; lg[c] = 0; ev[c] = 0; sr[c] = 0; g[c] = 0;
      for (int m = 0; m < N; m++) begin idv[c][m] = '0; pay[c][m] = '0; end
    end
    drive();
    s_r_valid = 0; s_r_id = 0; s_r_data = 0; s_r_last = 0; m_r_ready = 0;
    s_b_valid = 0; s_b_id = 0; s_b_resp = 0; m_b_ready = 0;
    void'($urandom(32'h1d5e7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R12", 64'({s_ar_valid, s_aw_valid, s_w_valid}), 64'd0);
    chk("R12", 64'({m_r_valid, m_b_valid}), 64'd0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        if (ev[c] && sr[c]) begin
          ptr[c] = g[c]; lock[c] = 0; vld[c][g[c]] = 1'b0;
        end else if (ev[c]) begin
          lock[c] = 1; lg[c] = g[c];
        end else lock[c] = 0;
        for (int m = 0; m < N; m++) begin
          if (!vld[c][m] && (cyc == 0 || $urandom % 3 == 0)) begin
            vld[c][m] = 1'b1;
            idv[c][m] = rand_id();
            pay[c][m] = {(c == 2) ? 1'($urandom) : 1'b0, 32'($urandom)};
          end
        end
        sr[c] = (cyc < 2) ? 1'b0 : ($urandom % 4 != 0);
      end
      drive();
      s_r_valid = 1'($urandom); s_r_id = 8'($urandom); s_r_data = $urandom;
      s_r_last = 1'($urandom); m_r_ready = 4'($urandom);
      if (cyc % 5 == 0) s_r_id[7:4] = 4'($urandom % 4);
      s_b_valid = 1'($urandom); s_b_id = 8'($urandom); s_b_resp = 2'($urandom);
      m_b_ready = 4'($urandom);
      if (cyc % 3 == 0) s_b_id[7:4] = 4'($urandom % 4);
      #2;
      check_req(0, cyc == 0, s_ar_valid, s_ar_id, {1'b0, s_ar_addr}, m_ar_ready);
      check_req(1, cyc == 0, s_aw_valid, s_aw_id, {1'b0, s_aw_addr}, m_aw_ready);
      check_req(2, cyc == 0, s_w_valid, s_w_id, {s_w_last, s_w_data}, m_w_ready);
      check_rsp(0, s_r_valid, s_r_id, m_r_ready, m_r_valid, m_r_id, s_r_ready);
      if (int'(s_r_id[7:4]) < N && s_r_valid)
        chk("R6", 64'({m_r_last, m_r_data}), 64'({s_r_last, s_r_data}));
      check_rsp(1, s_b_valid, s_b_id, m_b_ready, m_b_valid, m_b_id, s_b_ready);
      if (int'(s_b_id[7:4]) < N && s_b_valid) chk("R8", 64'(m_b_resp), 64'(s_b_resp));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule